// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave with Lockable Identification Page

This block is the slave side of a two-wire serial EEPROM. It sees SCL and SDA through a short synchronizer running on the system clock. It pulls SDA low through an open-drain enable. It answers to two device type codes. One selects a byte-wide main array of configurable size. The other selects a separate 128-byte identification page. The three low address bits of the device byte are compared against strap pins.

Writes arrive as a two-byte word address followed by data bytes. Accepted bytes go straight into the selected storage. A STOP that follows at least one accepted data byte starts a simulated internal write cycle of a fixed number of clocks. During that cycle the device byte is not acknowledged, so a master can poll until the part answers again.

Reads can start from the retained address counter, or from an address loaded by a dummy write. Reading continues for as long as the master acknowledges each byte. A one-time lock instruction makes the identification page read-only. After a lock, only a reset clears the flag; no real non-volatile storage is modelled.

Top module: `twowire_eeprom`

## Requirements
- R1: After reset SDA is released (`sda_oe` = 0) and the block waits for a START.
- R2: A device byte is acknowledged only when bits [7:4] are 1010 (main array) or 1011 (identification page), bits [3:1] equal `cs_strap`, and no write cycle is running. Bit 0 is R/W, with 1 meaning read. Any other byte is not acknowledged and the block ignores the bus until the next START.
- R3: A write carries the word address as two bytes, high byte first, and both bytes are acknowledged.
- R4: Main-array data bytes are acknowledged and written at the counter. The counter's low PAGE_W bits then increment and wrap within the page. A STOP after at least one acknowledged data byte starts a write cycle of WR_CYCLES clocks.
- R5: While the write cycle runs, a START plus device byte gets no acknowledge. Once the cycle ends, the same byte is acknowledged and the transaction proceeds.
- R6: The address counter holds the last accessed address plus one and keeps it between transactions. A read with no address phase returns the byte at the counter.
- R7: A random read consists of a dummy write of the word address, a repeated START and a read device byte. Bytes keep coming while the master drives ACK (SDA low), and the read ends on a NoACK.
- R8: Main-array reads wrap from the last byte of the array to byte 0.
- R9: With type 1011 and word address bit 10 = 0, data bytes go to the identification page at address bits [6:0], wrapping within the 128 bytes. Reads with type 1011 return page bytes the same way. The main array is left untouched.
- R10: With type 1011 and word address bit 10 = 1, a data byte with bit 1 set is acknowledged and locks the page. A data byte with bit 1 clear is not acknowledged and does not lock the page.
- R11: Once locked, identification-page data bytes and further lock bytes are not acknowledged, the page contents do not change and no write cycle starts. Reads of the page still work.
- R12: `sda_oe` changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| cs_strap | input | 3 | Chip-select strap compared with device byte bits [3:1] |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |

## Verification
A wrong address counter shows up on the very next read as a wrong byte. A broken page wrap or array wrap shows up when a read crosses that boundary. A write cycle that never starts or never ends shows up as an acknowledge pattern that is wrong on the first poll after STOP. A lock flag that is lost or set too early shows up on the acknowledge bit of the next identification-page data byte. Any of these shows up within one byte time on SDA.

// File: rtl/twe_pkg.sv
package twe_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_RXACK, S_TX, S_TXACK
  } twe_state_e;

  typedef enum logic [1:0] {
    P_DEV, P_AHI, P_ALO, P_DATA
  } twe_phase_e;

  localparam logic [3:0] TYPE_MAIN = 4'b1010;
  localparam logic [3:0] TYPE_IDPG = 4'b1011;
  localparam int ID_W        = 7;   // 128-byte identification page
  localparam int LOCK_ABIT   = 10;  // word address bit choosing lock vs write
  localparam int LOCK_DBIT   = 1;   // data bit that must be set to lock

  // increment the low pw bits, keep the rest (page-bounded wrap)
  function automatic logic [15:0] page_next(input logic [15:0] a, input int pw);
    logic [15:0] m;
    m = 16'((32'd1 << pw) - 32'd1);
    return (a & ~m) | ((a + 16'd1) & m);
  endfunction

  // increment and wrap over the whole aw-bit space
  function automatic logic [15:0] wrap_next(input logic [15:0] a, input int aw);
    logic [15:0] m;
    m = 16'((32'd1 << aw) - 32'd1);
    return (a + 16'd1) & m;
  endfunction

endpackage

// File: rtl/twe_sync.sv
module twe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic ev_start,
  output logic ev_stop,
  output logic scl_rise,
  output logic scl_fall
);
  logic [STAGES-1:0] scl_p, sda_p;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_p <= {scl_p[STAGES-2:0], scl_i};
      sda_p <= {sda_p[STAGES-2:0], sda_i};
      scl_q <= scl_p[STAGES-1];
      sda_q <= sda_p[STAGES-1];
    end
  end

  assign scl_s    = scl_p[STAGES-1];
  assign sda_s    = sda_p[STAGES-1];
  assign ev_start = scl_s && scl_q && sda_q && !sda_s;
  assign ev_stop  = scl_s && scl_q && !sda_q && sda_s;
  assign scl_rise = scl_s && !scl_q;
  assign scl_fall = !scl_s && scl_q;
endmodule

// File: rtl/twe_mem.sv
module twe_mem #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/twowire_eeprom.sv
module twowire_eeprom
  import twe_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int PAGE_W      = 5,
  parameter int WR_CYCLES   = 5000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] cs_strap,
  output logic       sda_oe
);
  localparam int BUSY_W = $clog2(WR_CYCLES + 1);

  // synchronized bus view
  logic scl_s, sda_s, ev_start, ev_stop, scl_rise, scl_fall;

  twe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .ev_start(ev_start), .ev_stop(ev_stop),
    .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  twe_state_e st;
  twe_phase_e ph;
  logic [2:0]        bitcnt;
  logic [7:0]        shreg, tx_sh;
  logic              rx_done, ack_q, more_q, sel_id, rw_q;
  logic [15:0]       ptr;
  logic              wr_pending, id_locked;
  logic [BUSY_W-1:0] busy_cnt;

  // named internal events
  logic        wr_busy, byte_evt, byte_ack, dev_match;
  logic        main_we, id_we, lock_set, ev_load, dev_ack_slot;
  logic [7:0]  rx_byte, main_rd, id_rd, rd_byte;
  logic [15:0] rd_next, wr_next;

  assign wr_busy      = busy_cnt != '0;
  assign byte_evt     = (st == S_RX) && scl_rise && (bitcnt == 3'd7);
  assign rx_byte      = {shreg[6:0], sda_s};
  assign dev_match    = ((rx_byte[7:4] == TYPE_MAIN) || (rx_byte[7:4] == TYPE_IDPG))
                        && (rx_byte[3:1] == cs_strap);
  assign dev_ack_slot = (st == S_RXACK) && (ph == P_DEV);
  assign rd_byte      = sel_id ? id_rd : main_rd;
  assign rd_next      = sel_id ? page_next(ptr, ID_W) : wrap_next(ptr, ADDR_W);
  assign wr_next      = sel_id ? page_next(ptr, ID_W) : page_next(ptr, PAGE_W);
  assign ev_load      = ((st == S_RXACK) && scl_fall && ack_q && (ph == P_DEV) && rw_q)
                        || ((st == S_TXACK) && scl_fall && more_q);

  always_comb begin
    byte_ack = 1'b0;
    main_we  = 1'b0;
    id_we    = 1'b0;
    lock_set = 1'b0;
    if (byte_evt) begin
      unique case (ph)
        P_DEV:          byte_ack = dev_match && !wr_busy;
        P_AHI, P_ALO:   byte_ack = 1'b1;
        P_DATA: begin
          if (!sel_id) begin
            byte_ack = 1'b1;
            main_we  = 1'b1;
          end else if (!ptr[LOCK_ABIT]) begin
            byte_ack = !id_locked;
            id_we    = !id_locked;
          end else begin
            byte_ack = !id_locked && rx_byte[LOCK_DBIT];
            lock_set = !id_locked && rx_byte[LOCK_DBIT];
          end
        end
        default: byte_ack = 1'b0;
      endcase
    end
  end

  twe_mem #(.AW(ADDR_W)) u_main (
    .clk(clk), .we(main_we), .waddr(ptr[ADDR_W-1:0]), .wdata(rx_byte),
    .raddr(ptr[ADDR_W-1:0]), .rdata(main_rd)
  );

  twe_mem #(.AW(ID_W)) u_idpg (
    .clk(clk), .we(id_we), .waddr(ptr[ID_W-1:0]), .wdata(rx_byte),
    .raddr(ptr[ID_W-1:0]), .rdata(id_rd)
  );

  // open-drain drive: ACK slot or a zero data bit
  assign sda_oe = ((st == S_RXACK) && ack_q) || ((st == S_TX) && !tx_sh[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      ph         <= P_DEV;
      bitcnt     <= '0;
      shreg      <= '0;
      tx_sh      <= '1;
      rx_done    <= 1'b0;
      ack_q      <= 1'b0;
      more_q     <= 1'b0;
      sel_id     <= 1'b0;
      rw_q       <= 1'b0;
      ptr        <= '0;
      wr_pending <= 1'b0;
      id_locked  <= 1'b0;
      busy_cnt   <= '0;
    end else begin
      if (ev_stop && wr_pending) busy_cnt <= BUSY_W'(WR_CYCLES);
      else if (wr_busy)          busy_cnt <= busy_cnt - BUSY_W'(1);

      if (lock_set) id_locked <= 1'b1;

      if (ev_load) begin
        tx_sh  <= rd_byte;
        ptr    <= rd_next;
        bitcnt <= '0;
        st     <= S_TX;
      end else if (ev_stop) begin
        st         <= S_IDLE;
        wr_pending <= 1'b0;
      end else if (ev_start) begin
        st      <= S_RX;
        ph      <= P_DEV;
        bitcnt  <= '0;
        rx_done <= 1'b0;
      end else begin
        unique case (st)
          S_RX: begin
            if (scl_rise) begin
              shreg  <= rx_byte;
              bitcnt <= bitcnt + 3'd1;
              if (bitcnt == 3'd7) begin
                rx_done <= 1'b1;
                ack_q   <= byte_ack;
                unique case (ph)
                  P_DEV: if (byte_ack) begin
                    sel_id <= (rx_byte[7:4] == TYPE_IDPG);
                    rw_q   <= rx_byte[0];
                  end
                  P_AHI: ptr[15:8] <= rx_byte;
                  P_ALO: ptr[7:0]  <= rx_byte;
                  P_DATA: begin
                    if (main_we || id_we) ptr <= wr_next;
                    if (byte_ack) wr_pending <= 1'b1;
                  end
                  default: ;
                endcase
              end
            end else if (scl_fall && rx_done) begin
              st      <= S_RXACK;
              rx_done <= 1'b0;
            end
          end
          S_RXACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (!ack_q) st <= S_IDLE;
              else begin
                st <= S_RX;
                unique case (ph)
                  P_DEV:   ph <= P_AHI;
                  P_AHI:   ph <= P_ALO;
                  default: ph <= P_DATA;
                endcase
              end
            end
          end
          S_TX: begin
            if (scl_fall) begin
              if (bitcnt == 3'd7) begin
                st     <= S_TXACK;
                more_q <= 1'b0;
              end else begin
                tx_sh  <= {tx_sh[6:0], 1'b1};
                bitcnt <= bitcnt + 3'd1;
              end
            end
          end
          S_TXACK: begin
            if (scl_rise) more_q <= !sda_s;
            else if (scl_fall) st <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/twe_checker.sv
module twe_checker (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic sda_oe,
  input logic wr_busy,
  input logic wr_pending,
  input logic ev_stop,
  input logic dev_ack_slot,
  input logic main_we,
  input logic id_we,
  input logic id_locked
);
  // R5: device byte never acknowledged during the write cycle
  a_r5_poll_nack: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_ack_slot && wr_busy) |-> !sda_oe);

  // R4: STOP after accepted data starts the write cycle
  a_r4_cycle_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop && wr_pending) |=> wr_busy);

  // R4: no storage writes while the cycle runs
  a_r4_no_write_busy: assert property (@(posedge clk) disable iff (!rst_n)
    wr_busy |-> !(main_we || id_we));

  // R10: lock flag never clears
  a_r10_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    id_locked |=> id_locked);

  // R11: locked page is never written
  a_r11_locked_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    id_locked |-> !id_we);

  // R12: drive changes only with SCL low
  a_r12_sda_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);
endmodule

bind twowire_eeprom twe_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .wr_busy(wr_busy), .wr_pending(wr_pending), .ev_stop(ev_stop),
  .dev_ack_slot(dev_ack_slot), .main_we(main_we), .id_we(id_we),
  .id_locked(id_locked)
);

// File: tb/twowire_eeprom_bench.sv
module twowire_eeprom_bench;
  localparam int WR  = 300;
  localparam int HW  = 12;          // clocks per SCL half period
  localparam logic [2:0] CS = 3'b101;
  localparam logic [7:0] MW = {4'b1010, CS, 1'b0};
  localparam logic [7:0] MR = {4'b1010, CS, 1'b1};
  localparam logic [7:0] IW = {4'b1011, CS, 1'b0};
  localparam logic [7:0] IR = {4'b1011, CS, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_oe;
  logic sda_bus;
  int n_checks = 0, n_fail = 0, viol = 0;
  logic prev_oe = 1'b0;
  logic [7:0] exp_q[$], got_q[$];
  string tag_q[$];

  always #2 clk = ~clk;   // 250 MHz
  assign sda_bus = m_sda & ~sda_oe;

  twowire_eeprom #(.WR_CYCLES(WR)) u_twowire_eeprom (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .cs_strap(CS), .sda_oe(sda_oe)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // R12 monitor: drive must not move while the master holds SCL high
  always @(posedge clk) begin
    if (rst_n && (sda_oe != prev_oe) && m_scl) viol++;
    prev_oe <= sda_oe;
  end

  // scoreboard monitor
  initial forever begin
    @(posedge clk);
    while (got_q.size() > 0) begin
      logic [7:0] g, e;
      string t;
      g = got_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(g == e, t, g, e);
    end
  end

  task automatic hw_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; hw_wait(HW);
    m_scl = 1'b1; hw_wait(HW);
    m_sda = 1'b0; hw_wait(HW);
    m_scl = 1'b0; hw_wait(HW);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; hw_wait(HW);
    m_scl = 1'b1; hw_wait(HW);
    m_sda = 1'b1; hw_wait(HW);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; hw_wait(HW);
      m_scl = 1'b1; hw_wait(HW);
      m_scl = 1'b0;
    end
    m_sda = 1'b1; hw_wait(HW);
    m_scl = 1'b1; hw_wait(HW / 2);
    acked = !sda_bus;
    hw_wait(HW / 2);
    m_scl = 1'b0;
  endtask

  task automatic send_chk(input logic [7:0] b, input bit exp_ack, input string tag);
    bit a;
    send_byte(b, a);
    check(a == exp_ack, tag, a, exp_ack);
  endtask

  task automatic recv_byte(input bit last);
    logic [7:0] b;
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hw_wait(HW);
      m_scl = 1'b1; hw_wait(HW / 2);
      b[i] = sda_bus;
      hw_wait(HW / 2);
      m_scl = 1'b0;
    end
    m_sda = last; hw_wait(HW);
    m_scl = 1'b1; hw_wait(HW);
    m_scl = 1'b0;
    m_sda = 1'b1;
    got_q.push_back(b);
  endtask

  task automatic expect_byte(input logic [7:0] b, input string tag);
    exp_q.push_back(b);
    tag_q.push_back(tag);
  endtask

  task automatic addr_phase(input logic [7:0] dev, input logic [15:0] a, input string tag);
    send_chk(dev, 1'b1, tag);
    send_chk(a[15:8], 1'b1, "R3 high address");
    send_chk(a[7:0], 1'b1, "R3 low address");
  endtask

  task automatic rand_read(input logic [7:0] dw, input logic [7:0] dr,
                           input logic [15:0] a, input int n);
    bus_start();
    addr_phase(dw, a, "R7 dummy write");
    bus_start();
    send_chk(dr, 1'b1, "R7 read device");
    for (int i = 0; i < n; i++) recv_byte(i == n - 1);
    bus_stop();
  endtask

  task automatic settle();
    hw_wait(WR + 20);
  endtask

  task automatic finish_run();
    hw_wait(10);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    hw_wait(5);
    check(sda_oe == 1'b0, "R1 reset release", sda_oe, 0);
    rst_n = 1'b1;
    hw_wait(20);
    check(sda_oe == 1'b0, "R1 idle release", sda_oe, 0);

    // main write near the array top
    bus_start();
    addr_phase(MW, 16'h03FE, "R2 main write device");
    send_chk(8'h11, 1'b1, "R4 data ack");
    send_chk(8'h22, 1'b1, "R4 data ack");
    bus_stop();

    // poll while busy
    bus_start();
    send_chk(MW, 1'b0, "R5 busy nack");
    bus_stop();
    settle();

    // poll after cycle, continue with a page-wrapping write
    bus_start();
    addr_phase(MW, 16'h001E, "R5 ready ack");
    send_chk(8'hA0, 1'b1, "R4 data ack");
    send_chk(8'hA1, 1'b1, "R4 data ack");
    send_chk(8'hA2, 1'b1, "R4 data ack");
    send_chk(8'hA3, 1'b1, "R4 data ack");
    bus_stop();
    settle();

    // read across the array end: 3FE, 3FF, then 000
    expect_byte(8'h11, "R7 first byte");
    expect_byte(8'h22, "R7 sequential");
    expect_byte(8'hA2, "R8 array wrap");
    rand_read(MW, MR, 16'h03FE, 3);

    // current address read -> address 001
    bus_start();
    send_chk(MR, 1'b1, "R6 read device");
    expect_byte(8'hA3, "R6 current address");
    recv_byte(1'b1);
    bus_stop();

    // page wrap on write left A0,A1 at 1E,1F
    expect_byte(8'hA0, "R4 page wrap");
    expect_byte(8'hA1, "R4 page wrap");
    rand_read(MW, MR, 16'h001E, 2);

    // wrong chip select
    bus_start();
    send_chk({4'b1010, 3'b001, 1'b0}, 1'b0, "R2 strap mismatch");
    send_chk(8'h00, 1'b0, "R2 ignored after mismatch");
    bus_stop();

    // identification page writes
    bus_start();
    addr_phase(IW, 16'h8805, "R9 id write device");
    send_chk(8'h5A, 1'b1, "R9 id data");
    send_chk(8'h5B, 1'b1, "R9 id data");
    bus_stop();
    settle();
    bus_start();
    addr_phase(IW, 16'h007F, "R9 id write device");
    send_chk(8'hC1, 1'b1, "R9 id data");
    send_chk(8'hC2, 1'b1, "R9 id wrap data");
    bus_stop();
    settle();

    expect_byte(8'h5A, "R9 id read");
    expect_byte(8'h5B, "R9 id read");
    rand_read(IW, IR, 16'h0005, 2);
    expect_byte(8'hC1, "R9 id read end");
    expect_byte(8'hC2, "R9 id wrap");
    rand_read(IW, IR, 16'h007F, 2);
    expect_byte(8'hA0, "R9 main untouched");
    rand_read(MW, MR, 16'h001E, 1);

    // lock with bit 1 clear: refused
    bus_start();
    addr_phase(IW, 16'h0400, "R10 lock device");
    send_chk(8'hFD, 1'b0, "R10 bad lock data");
    bus_stop();
    bus_start();
    addr_phase(IW, 16'h0007, "R10 still unlocked");
    send_chk(8'h77, 1'b1, "R10 write before lock");
    bus_stop();
    settle();

    // valid lock
    bus_start();
    addr_phase(IW, 16'h0C33, "R10 lock device");
    send_chk(8'h02, 1'b1, "R10 lock accepted");
    bus_stop();
    settle();

    // locked: data refused, no write cycle, contents kept
    bus_start();
    addr_phase(IW, 16'h0005, "R11 locked device");
    send_chk(8'h99, 1'b0, "R11 locked data nack");
    bus_stop();
    expect_byte(8'h5A, "R11 content kept");
    rand_read(IW, IR, 16'h0005, 1);
    expect_byte(8'h77, "R10 pre-lock byte");
    rand_read(IW, IR, 16'h0007, 1);
    bus_start();
    addr_phase(IW, 16'h0400, "R11 relock device");
    send_chk(8'h02, 1'b0, "R11 relock nack");
    bus_stop();

    check(viol == 0, "R12 sda moved with scl high", viol, 0);
    finish_run();
  end
endmodule